// File: doc/BRIEF.md
# Shift-Double and Field Deposit Unit

This block is a 32-bit two-operation datapath unit for a processor execution stage. The first operation, shift-double, treats operand A as the upper word and operand B as the lower word of a 64-bit value. It shifts that value right by a count of 0 to 31 and returns the lower 32 bits. The second operation, deposit, takes the low-order `len` bits of operand A and writes them into operand B as a field. Every bit of B outside that field is kept.

Deposit positions use most-significant-first numbering: position 0 is the MSB and position 31 is the LSB. The `pos` input names the position of the field's least significant bit, so the field extends from there toward the MSB. With only these two operations, a full byte reverse of a word takes three issues: a shift-double of a word with itself by 16, a deposit of 8 bits at position 15, and a shift-double by 8.

Each operation is presented for one cycle with `opValid` high. The result is registered and appears one clock later. It then stays unchanged until the next valid operation.

Top module: `sdd_unit`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `result` is 0 and `resultValid` is 0.
- R2: `resultValid` is 1 in exactly the cycle after a cycle with `opValid` high, and 0 after a cycle with `opValid` low.
- R3: With `opSel`=0 (shift-double), `result` becomes the lower 32 bits of the 64-bit value {opA, opB} shifted right by `pos` bits.
- R4: A shift-double with `pos`=0 returns `opB` unchanged.
- R5: With `opSel`=1 (deposit), bit k of the low field of `opA` (k = 0 .. len-1) lands at most-significant-first position `pos`-k. That is register bit 31-`pos`+k, so the field's LSB sits at register bit 31-`pos`.
- R6: A deposit leaves every bit of `opB` outside the written field at its original value.
- R7: When `len` exceeds `pos`+1, only field bits 0..`pos` are written, covering positions `pos` up to 0. The higher field bits are dropped and nothing wraps to the low end of the word.
- R8: A deposit with `len`=0 returns `opB` unchanged.
- R9: A deposit with `len`=32 and `pos`=31 returns `opA` unchanged.
- R10: While `opValid` is low, `result` holds its value whatever the other inputs do.
- R11: Starting from 0x11223344, the three-step sequence returns 0x44332211. The steps are: shift-double of the word with itself by 16, then deposit of that result into itself with `pos`=15 and `len`=8, then shift-double of {original, deposit result} by 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 1 | 0 selects shift-double, 1 selects deposit |
| opA | input | 32 | Upper word for shift-double; field source for deposit |
| opB | input | 32 | Lower word for shift-double; target word for deposit |
| pos | input | 5 | Shift count, or the most-significant-first position of the field LSB |
| len | input | 6 | Deposit field length, 0 to 32 |
| result | output | 32 | Registered result |
| resultValid | output | 1 | `result` was updated on the last clock edge |

## Verification
The bench sweeps every shift count over several operand pairs, and every position against every length from 0 to 32 for three source/target pairs. Each result is compared with an arithmetic model built in most-significant-first terms.

The sweep targets these corner cases:
- **Shift count 0 and 31.** A funnel built with its operand order swapped returns `opA` instead of `opB` at count 0. One that drops the top window bit fails at 31.
- **Fields that run past position 0.** A mask that wraps instead of clipping corrupts the low bits of the target.
- **Lengths 0 and 32.** An off-by-one length decode writes a stray bit or leaves one stale.
- **Position numbering.** Any confusion between register bits and most-significant-first positions mirrors the field across the word.

The byte-reverse chain catches a unit that is right on isolated cases but has the field pointing the wrong way.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  // Operation encoding on opSel
  typedef enum logic {
    OP_SHIFT_DOUBLE = 1'b0,
    OP_DEPOSIT      = 1'b1
  } sddOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // load the result register this edge
    logic pickDeposit;  // select the deposit path instead of the funnel
  } sddStrobe_t;

endpackage

// File: rtl/sdd_funnel.sv
// Funnel shifter: lower WIDTH bits of {upper, lower} >> amt.
// The top bit of the upper word can never reach the output for amt < WIDTH,
// so only WIDTH-1 upper bits are taken.
module sdd_funnel #(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-2:0]   upperBits,
  input  logic [WIDTH-1:0]   lowerWord,
  input  logic [POS_W-1:0]   amt,
  output logic [WIDTH-1:0]   shifted
);

  localparam int CAT_W = 2 * WIDTH - 1;

  logic [CAT_W-1:0] catBits;
  assign catBits = {upperBits, lowerWord};

  // Each output bit selects from its own WIDTH-bit window of the concatenation.
  for (genvar i = 0; i < WIDTH; i++) begin : g_outBit
    logic [WIDTH-1:0] window;
    assign window     = catBits[i +: WIDTH];
    assign shifted[i] = window[amt];
  end

endmodule

// File: rtl/sdd_deposit.sv
// Field deposit with most-significant-first positions.
// The field LSB goes to register bit (WIDTH-1-pos) and extends toward the MSB,
// clipped at the top of the word.
module sdd_deposit #(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH),
  localparam int LEN_W = POS_W + 1
) (
  input  logic [WIDTH-1:0]   fieldSrc,
  input  logic [WIDTH-1:0]   targetWord,
  input  logic [POS_W-1:0]   pos,
  input  logic [LEN_W-1:0]   len,
  output logic [WIDTH-1:0]   merged
);

  localparam int EXT_W = LEN_W + 1;

  logic [POS_W-1:0] lsbReg;    // register index of the field LSB
  logic [EXT_W-1:0] lsbExt;
  logic [EXT_W-1:0] lenExt;
  logic [WIDTH-1:0] aligned;
  logic [WIDTH-1:0] fieldMask;

  assign lsbReg  = POS_W'(WIDTH - 1) - pos;
  assign lsbExt  = EXT_W'(lsbReg);
  assign lenExt  = EXT_W'(len);
  assign aligned = fieldSrc << lsbReg;

  // Per-bit range test: bit i is in the field when lsb <= i < lsb + len.
  for (genvar i = 0; i < WIDTH; i++) begin : g_maskBit
    localparam logic [EXT_W-1:0] BIT_IDX = EXT_W'(i);
    logic [EXT_W-1:0] offset;
    assign offset       = BIT_IDX - lsbExt;
    assign fieldMask[i] = (BIT_IDX >= lsbExt) && (offset < lenExt);
  end

  assign merged = (targetWord & ~fieldMask) | (aligned & fieldMask);

endmodule

// File: rtl/sdd_ctrl.sv
// Control: turns the operation request into datapath strobes and tracks
// output validity.
module sdd_ctrl
  import sdd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic       opSel,
  output sddStrobe_t strobe,
  output logic       resultValid
);

  sddOp_e opKind;
  assign opKind = sddOp_e'(opSel);

  always_comb begin
    strobe             = '0;
    strobe.capture     = opValid;
    strobe.pickDeposit = (opKind == OP_DEPOSIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= opValid;
  end

endmodule

// File: rtl/sdd_datapath.sv
// Datapath: funnel shifter and deposit merge side by side, one result register.
module sdd_datapath
  import sdd_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH),
  localparam int LEN_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  sddStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] shiftOut;
  logic [WIDTH-1:0] depositOut;
  logic [WIDTH-1:0] nextResult;

  sdd_funnel #(.WIDTH(WIDTH)) u_funnel (
    .upperBits (opA[WIDTH-2:0]),
    .lowerWord (opB),
    .amt       (pos),
    .shifted   (shiftOut)
  );

  sdd_deposit #(.WIDTH(WIDTH)) u_deposit (
    .fieldSrc   (opA),
    .targetWord (opB),
    .pos        (pos),
    .len        (len),
    .merged     (depositOut)
  );

  assign nextResult = strobe.pickDeposit ? depositOut : shiftOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              result <= '0;
    else if (strobe.capture) result <= nextResult;
  end

endmodule

// File: rtl/sdd_unit.sv
// Top: shift-double and field deposit unit.
module sdd_unit
  import sdd_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH),
  localparam int LEN_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic             opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  output logic [WIDTH-1:0] result,
  output logic             resultValid
);

  sddStrobe_t strobe;

  sdd_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opSel       (opSel),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  sdd_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .pos    (pos),
    .len    (len),
    .result (result)
  );

endmodule

// File: rtl/sdd_unit_chk.sv
// Property checker, bound to the top.
module sdd_unit_chk #(
  parameter int WIDTH = 32,
  localparam int POS_W = $clog2(WIDTH),
  localparam int LEN_W = POS_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic             opSel,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [POS_W-1:0] pos,
  input logic [LEN_W-1:0] len,
  input logic [WIDTH-1:0] result,
  input logic             resultValid
);

  // R1: reset clears the output register and the valid flag
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (result == '0) && !resultValid);

  // R2: valid follows the request one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resultValid);

  // R2: no request, no valid
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resultValid);

  // R10: result held while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(result));

  // R4: zero shift returns the lower word
  a_r4_zero_shift: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSel && pos == '0) |=> (result == $past(opB)));

  // R8: empty field leaves the target untouched
  a_r8_empty_field: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel && len == '0) |=> (result == $past(opB)));

  // R9: full-width field at the last position replaces the whole word
  a_r9_full_field: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel && len == LEN_W'(WIDTH) && pos == POS_W'(WIDTH - 1))
      |=> (result == $past(opA)));

endmodule

bind sdd_unit sdd_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opValid     (opValid),
  .opSel       (opSel),
  .opA         (opA),
  .opB         (opB),
  .pos         (pos),
  .len         (len),
  .result      (result),
  .resultValid (resultValid)
);

// File: tb/sdd_unit_bench.sv
`timescale 1ns/1ps
module sdd_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic        opSel = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  pos = '0;
  logic [5:0]  len = '0;
  logic [31:0] result;
  logic        resultValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdd_unit u_sdd_unit (
    .clk         (clk),
    .rstN        (rstN),
    .opValid     (opValid),
    .opSel       (opSel),
    .opA         (opA),
    .opB         (opB),
    .pos         (pos),
    .len         (len),
    .result      (result),
    .resultValid (resultValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Reference models, written in most-significant-first terms.
  function automatic logic [31:0] refShift(input logic [31:0] a, input logic [31:0] b, input int p);
    logic [63:0] cat;
    cat = {a, b} >> p;
    return cat[31:0];
  endfunction

  function automatic logic [31:0] refDeposit(input logic [31:0] a, input logic [31:0] b,
                                            input int p, input int l);
    logic [31:0] r;
    r = b;
    for (int be = 0; be < 32; be++) begin
      int k;
      k = p - be;
      if (k >= 0 && k < l) r[31 - be] = a[k];
    end
    return r;
  endfunction

  // Issue one operation, check the registered result, then idle one cycle
  // with scrambled inputs and check that the result holds.
  task automatic doOp(input logic sel, input logic [31:0] a, input logic [31:0] b,
                      input int p, input int l, input logic [31:0] exp, input string req);
    @(negedge clk);
    opValid = 1'b1; opSel = sel; opA = a; opB = b; pos = p[4:0]; len = l[5:0];
    @(negedge clk);
    opValid = 1'b0;
    check(req, result, exp);
    check("R2 valid after op", {31'b0, resultValid}, 32'd1);
    opA = ~a; opB = ~b; pos = ~pos; opSel = ~sel; len = 6'd13;
    @(negedge clk);
    check("R10 hold while idle", result, exp);
    check("R2 valid drops", {31'b0, resultValid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    logic [31:0] shA [4];
    logic [31:0] shB [4];
    logic [31:0] dpA [3];
    logic [31:0] dpB [3];
    logic [31:0] t1, t2, t3;

    shA[0] = 32'h89AB_CDEF; shB[0] = 32'h0123_4567;
    shA[1] = 32'hFFFF_0000; shB[1] = 32'h0000_FFFF;
    shA[2] = 32'hA5C3_0F96; shB[2] = 32'hA5C3_0F96;
    shA[3] = 32'h8000_0001; shB[3] = 32'h7FFF_FFFE;
    dpA[0] = 32'hDEAD_BEEF; dpB[0] = 32'h0000_0000;
    dpA[1] = 32'h0000_0000; dpB[1] = 32'hFFFF_FFFF;
    dpA[2] = 32'h1357_9BDF; dpB[2] = 32'h2468_ACE0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 result in reset", result, 32'h0);
    check("R1 valid in reset", {31'b0, resultValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after reset", result, 32'h0);
    check("R1 valid after reset", {31'b0, resultValid}, 32'd0);

    // R3 / R4: shift-double over every count
    for (int v = 0; v < 4; v++) begin
      for (int p = 0; p < 32; p++) begin
        doOp(1'b0, shA[v], shB[v], p, 0, refShift(shA[v], shB[v], p),
             (p == 0) ? "R4 zero shift" : "R3 shift-double");
      end
    end

    // R5..R9: deposit over every position and length
    for (int v = 0; v < 3; v++) begin
      for (int p = 0; p < 32; p++) begin
        for (int l = 0; l <= 32; l++) begin
          string tag;
          if (l == 0)                 tag = "R8 empty field";
          else if (l == 32 && p == 31) tag = "R9 full field";
          else if (l > p + 1)          tag = "R7 clipped field";
          else if (v == 1)             tag = "R6 target bits kept";
          else                         tag = "R5 deposit";
          doOp(1'b1, dpA[v], dpB[v], p, l, refDeposit(dpA[v], dpB[v], p, l), tag);
        end
      end
    end

    // R11: three-step byte reverse
    doOp(1'b0, 32'h1122_3344, 32'h1122_3344, 16, 0, 32'h3344_1122, "R11 step1");
    t1 = result;
    doOp(1'b1, t1, t1, 15, 8, 32'h3322_1122, "R11 step2");
    t2 = result;
    doOp(1'b0, 32'h1122_3344, t2, 8, 0, 32'h4433_2211, "R11 reversed");
    t3 = result;
    check("R11 final word", t3, 32'h4433_2211);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule